// File: doc/BRIEF.md
# Inter-processor mailbox with lock bank

This block lets an application CPU and a small MCU exchange short messages and share resources safely. It holds four message slots. Each slot stores a 32-bit data word, a 32-bit command word and a pending flag. A sender writes the data word first and then the command word. Writing the command word raises the slot's pending flag. That flag interrupts the opposite processor if that processor has enabled it. The receiver reads both words and then clears the flag by writing a one to its status bit. Slots 0 and 1 carry traffic from the CPU to the MCU. Slots 2 and 3 carry traffic from the MCU to the CPU.

A separate bank of 32 lock bits gives software a test-and-set primitive for claiming the mailbox or any other shared resource. Each processor reaches the same word-addressed register map through its own port. Reads return data in the same cycle, and a lock read takes effect at the next clock edge. If both sides touch the same lock in one cycle, the CPU side takes priority.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset all pending flags, interrupt enables and locks are zero, and both interrupt outputs are low.
- R2: Slot i (0..3) keeps its data word at word address 0x00+i and its command word at 0x04+i, and either side can read both. Only the sending side can write them (the CPU for slots 0–1, the MCU for slots 2–3). A write from the other side leaves the stored value unchanged.
- R3: A command-word write by the sending side sets bit i of the status register (address 0x08, bits [3:0]) from the next cycle on. A data-word write leaves the flag unchanged.
- R4: Writing the status register clears the flags whose write-data bit is one, but only for slots addressed to the writing side. Zero bits, and bits of slots the writer sends, have no effect.
- R5: When a command write sets a flag in the same cycle that the receiver clears it, the flag ends up set.
- R6: Each side has its own interrupt-enable register at address 0x0C, bits [3:0], one bit per slot. A side reads back its own register.
- R7: The CPU interrupt is the OR of flag AND enable over slots 2–3 using the CPU enables. The MCU interrupt is the same over slots 0–1 using the MCU enables. Both follow register state in the cycle after the update.
- R8: A read at address 0x40+n (n = 0..31) returns bit 0 = 1 if lock n was already held and 0 if it was free, and leaves lock n held.
- R9: Writing address 0x40+n with write-data bit 0 equal to 0 releases lock n, from either side. A write with bit 0 equal to 1 has no effect.
- R10: When both sides read the same free lock in one cycle, the CPU read returns 0, the MCU read returns 1, and the lock ends up held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_en | input | 1 | CPU access strobe |
| cpu_we | input | 1 | CPU access is a write |
| cpu_addr | input | 7 | CPU word address |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | CPU read data, same cycle |
| mcu_en | input | 1 | MCU access strobe |
| mcu_we | input | 1 | MCU access is a write |
| mcu_addr | input | 7 | MCU word address |
| mcu_wdata | input | 32 | MCU write data |
| mcu_rdata | output | 32 | MCU read data, same cycle |
| cpu_irq | output | 1 | Interrupt toward the CPU |
| mcu_irq | output | 1 | Interrupt toward the MCU |

## Verification
The bound checks run on every cycle. They cover four behaviours: a command write always raises its flag, a flag only drops when the receiver writes the clear, a lock read that returns free always leaves the lock held, and a same-lock race never grants the lock to both sides. They also confirm that neither interrupt is raised without a pending flag on its own side. Other behaviours can only be shown by the bench's scenarios: write ownership of the slot words, the exact OR of flags with each enable pattern, the set-over-clear collision, and the release and ignore rules of the lock bank across all 32 locks.

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
  parameter int NELEM = 4,
  parameter int NLOCK = 32,
  parameter int DW    = 32,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_en,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic          mcu_en,
  input  logic          mcu_we,
  input  logic [AW-1:0] mcu_addr,
  input  logic [DW-1:0] mcu_wdata,
  output logic [DW-1:0] mcu_rdata,
  output logic          cpu_irq,
  output logic          mcu_irq
);
  localparam int EW   = $clog2(NELEM);
  localparam int LW   = $clog2(NLOCK);
  localparam int HALF = NELEM / 2;
  localparam logic [NELEM-1:0] TO_MCU = NELEM'((1 << HALF) - 1);
  localparam logic [NELEM-1:0] TO_CPU = ~TO_MCU;
  localparam logic [NELEM-1:0] SENDM [2] = '{TO_MCU, TO_CPU};
  localparam logic [NELEM-1:0] RECVM [2] = '{TO_CPU, TO_MCU};

  logic [1:0]    en, we, is_lock, wr_reg, rd_lock;
  logic [AW-1:0] ad [2];
  logic [DW-1:0] wd [2];
  logic [DW-1:0] rd [2];
  logic [1:0]    kind [2];
  logic [EW-1:0] idx [2];
  logic [LW-1:0] lidx [2];

  logic [DW-1:0]    data_q [NELEM];
  logic [DW-1:0]    cmd_q  [NELEM];
  logic [NELEM-1:0] ien_q  [2];
  logic [NELEM-1:0] flag_q, set_v, clr_v;
  logic [NLOCK-1:0] lock_q, lock_d;

  assign en = {mcu_en, cpu_en};
  assign we = {mcu_we, cpu_we};
  assign ad[0] = cpu_addr;
  assign ad[1] = mcu_addr;
  assign wd[0] = cpu_wdata;
  assign wd[1] = mcu_wdata;
  assign cpu_rdata = rd[0];
  assign mcu_rdata = rd[1];

  logic same_lock;
  assign same_lock = rd_lock[0] && (lidx[0] == lidx[1]);

  for (genvar s = 0; s < 2; s++) begin : g_side
    assign is_lock[s] = ad[s][AW-1];
    assign kind[s]    = ad[s][EW+1:EW];
    assign idx[s]     = ad[s][EW-1:0];
    assign lidx[s]    = ad[s][LW-1:0];
    assign wr_reg[s]  = en[s] && we[s] && !is_lock[s];
    assign rd_lock[s] = en[s] && !we[s] && is_lock[s];

    always_comb begin
      if (is_lock[s])
        rd[s] = {{(DW-1){1'b0}}, lock_q[lidx[s]] | ((s == 1) && same_lock)};
      else
        case (kind[s])
          2'd0:    rd[s] = data_q[idx[s]];
          2'd1:    rd[s] = cmd_q[idx[s]];
          2'd2:    rd[s] = DW'(flag_q);
          default: rd[s] = DW'(ien_q[s]);
        endcase
    end
  end

  always_comb begin
    set_v = '0;
    clr_v = '0;
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < NELEM; i++) begin
        if (wr_reg[s] && kind[s] == 2'd1 && idx[s] == EW'(i) && SENDM[s][i]) set_v[i] = 1'b1;
        if (wr_reg[s] && kind[s] == 2'd2 && wd[s][i] && RECVM[s][i])           clr_v[i] = 1'b1;
      end
  end

  always_comb begin
    lock_d = lock_q;
    for (int s = 1; s >= 0; s--)
      if (en[s] && is_lock[s]) begin
        if (!we[s])             lock_d[lidx[s]] = 1'b1;
        else if (!wd[s][0])     lock_d[lidx[s]] = 1'b0;
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q   <= '0;
      lock_q   <= '0;
      ien_q[0] <= '0;
      ien_q[1] <= '0;
      for (int i = 0; i < NELEM; i++) begin
        data_q[i] <= '0;
        cmd_q[i]  <= '0;
      end
    end else begin
      flag_q <= (flag_q & ~clr_v) | set_v;
      lock_q <= lock_d;
      for (int s = 0; s < 2; s++) begin
        if (wr_reg[s] && SENDM[s][idx[s]]) begin
          if (kind[s] == 2'd0) data_q[idx[s]] <= wd[s];
          if (kind[s] == 2'd1) cmd_q[idx[s]]  <= wd[s];
        end
        if (wr_reg[s] && kind[s] == 2'd3) ien_q[s] <= wd[s][NELEM-1:0];
      end
    end
  end

  assign cpu_irq = |(flag_q & ien_q[0] & TO_CPU);
  assign mcu_irq = |(flag_q & ien_q[1] & TO_MCU);
endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk #(
  parameter int NELEM = 4,
  parameter int NLOCK = 32,
  parameter int DW    = 32,
  parameter int AW    = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_en,
  input logic             cpu_we,
  input logic [AW-1:0]    cpu_addr,
  input logic [DW-1:0]    cpu_wdata,
  input logic [DW-1:0]    cpu_rdata,
  input logic             mcu_en,
  input logic             mcu_we,
  input logic [AW-1:0]    mcu_addr,
  input logic [DW-1:0]    mcu_wdata,
  input logic [DW-1:0]    mcu_rdata,
  input logic             cpu_irq,
  input logic             mcu_irq,
  input logic [NELEM-1:0] flag_q,
  input logic [NLOCK-1:0] lock_q
);
  localparam int LW   = $clog2(NLOCK);
  localparam int HALF = NELEM / 2;

  // R3
  cmd_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_en && cpu_we && !cpu_addr[AW-1] && cpu_addr[3:2] == 2'd1 && cpu_addr[1:0] == 2'd0) |=> flag_q[0]);

  // R4
  flag_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q[0]) |-> $past(mcu_en && mcu_we && !mcu_addr[AW-1] && mcu_addr[3:2] == 2'd2 && mcu_wdata[0]));

  // R8
  lock_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_en && !cpu_we && cpu_addr[AW-1] && !cpu_rdata[0]) |=> lock_q[$past(cpu_addr[LW-1:0])]);

  // R10
  lock_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_en && !cpu_we && cpu_addr[AW-1] && mcu_en && !mcu_we && mcu_addr[AW-1] &&
     cpu_addr[LW-1:0] == mcu_addr[LW-1:0]) |-> mcu_rdata[0]);

  // R7
  cpu_irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> |flag_q[NELEM-1:HALF]);

  // R7
  mcu_irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mcu_irq |-> |flag_q[HALF-1:0]);
endmodule

bind ipc_mailbox ipc_mailbox_chk #(.NELEM(NELEM), .NLOCK(NLOCK), .DW(DW), .AW(AW)) u_chk (.*);

// File: tb/ipc_mailbox_test.sv
module ipc_mailbox_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_en = 0, cpu_we = 0, mcu_en = 0, mcu_we = 0;
  logic [6:0] cpu_addr = '0, mcu_addr = '0;
  logic [31:0] cpu_wdata = '0, mcu_wdata = '0;
  logic [31:0] cpu_rdata, mcu_rdata;
  logic cpu_irq, mcu_irq;
  int checks = 0, fails = 0;

  ipc_mailbox uut (.*);

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic acc(input bit s, input bit w, input logic [6:0] a, input logic [31:0] d,
                     output logic [31:0] r);
    @(negedge clk);
    if (s) begin mcu_en = 1; mcu_we = w; mcu_addr = a; mcu_wdata = d; end
    else   begin cpu_en = 1; cpu_we = w; cpu_addr = a; cpu_wdata = d; end
    #1 r = s ? mcu_rdata : cpu_rdata;
    @(posedge clk); #1;
    cpu_en = 0; mcu_en = 0;
  endtask

  task automatic both(input bit cw, input logic [6:0] ca, input logic [31:0] cd,
                      input bit mw, input logic [6:0] ma, input logic [31:0] md,
                      output logic [31:0] cr, output logic [31:0] mr);
    @(negedge clk);
    cpu_en = 1; cpu_we = cw; cpu_addr = ca; cpu_wdata = cd;
    mcu_en = 1; mcu_we = mw; mcu_addr = ma; mcu_wdata = md;
    #1 cr = cpu_rdata; mr = mcu_rdata;
    @(posedge clk); #1;
    cpu_en = 0; mcu_en = 0;
  endtask

  function automatic bit sender(input int e);
    return e >= 2;
  endfunction

  logic [31:0] r, r2;
  logic [3:0] fl;

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    @(negedge clk);
    chk("R1 cpu_irq", {31'b0, cpu_irq}, 0);
    chk("R1 mcu_irq", {31'b0, mcu_irq}, 0);
    acc(0, 0, 7'h08, 0, r); chk("R1 status", r, 0);
    acc(0, 0, 7'h0C, 0, r); chk("R1 cpu enable", r, 0);
    acc(1, 0, 7'h0C, 0, r); chk("R1 mcu enable", r, 0);
    acc(1, 0, 7'h5F, 0, r); chk("R1 lock 31 free", r, 0);
    acc(1, 1, 7'h5F, 0, r);

    // R2 / R3 data, command and flags
    fl = '0;
    for (int e = 0; e < 4; e++) begin
      logic [31:0] dv, cv;
      dv = 32'h1000_0000 + 32'(e) * 32'h0101_0101;
      cv = 32'hC000_0000 + 32'(e);
      acc(sender(e), 1, 7'(e), dv, r);
      acc(0, 0, 7'h08, 0, r); chk("R3 data write no flag", r, {28'b0, fl});
      acc(sender(e), 1, 7'(4 + e), cv, r);
      fl[e] = 1'b1;
      acc(!sender(e), 0, 7'h08, 0, r); chk("R3 cmd sets flag", r, {28'b0, fl});
      acc(!sender(e), 1, 7'(e), 32'hDEAD_BEEF, r);
      acc(!sender(e), 1, 7'(4 + e), 32'hBAD0_0000, r);
      acc(!sender(e), 0, 7'(e), 0, r);     chk("R2 data readback", r, dv);
      acc(sender(e), 0, 7'(4 + e), 0, r);  chk("R2 cmd readback", r, cv);
    end

    // R4 clear rules
    acc(1, 1, 7'h08, 32'hC, r);
    acc(0, 1, 7'h08, 32'h3, r);
    acc(0, 0, 7'h08, 0, r); chk("R4 sender clear ignored", r, 32'hF);
    acc(0, 1, 7'h08, 32'hF, r);
    acc(1, 0, 7'h08, 0, r); chk("R4 cpu clears own", r, 32'h3);
    acc(1, 1, 7'h08, 32'h1, r);
    acc(1, 0, 7'h08, 0, r); chk("R4 mcu clears bit0 only", r, 32'h2);
    acc(1, 1, 7'h08, 32'h2, r);
    acc(1, 0, 7'h08, 0, r); chk("R4 all clear", r, 0);

    // R6 / R7 sweep over flag and enable patterns
    for (int fp = 0; fp < 4; fp++) begin
      fl = {2'(fp), 2'(fp)};
      for (int e = 0; e < 4; e++)
        if (fl[e]) acc(sender(e), 1, 7'(4 + e), 32'(e), r);
      for (int en = 0; en < 16; en++) begin
        acc(0, 1, 7'h0C, 32'(en), r);
        acc(1, 1, 7'h0C, 32'(15 - en), r);
        @(negedge clk);
        chk("R7 cpu_irq", {31'b0, cpu_irq}, {31'b0, |(4'(en) & fl & 4'b1100)});
        chk("R7 mcu_irq", {31'b0, mcu_irq}, {31'b0, |(4'(15 - en) & fl & 4'b0011)});
        acc(0, 0, 7'h0C, 0, r); chk("R6 cpu enable", r, 32'(en));
        acc(1, 0, 7'h0C, 0, r); chk("R6 mcu enable", r, 32'(15 - en));
      end
      acc(0, 1, 7'h08, 32'hF, r);
      acc(1, 1, 7'h08, 32'hF, r);
    end
    acc(0, 0, 7'h08, 0, r); chk("R4 sweep cleared", r, 0);

    // R5 set wins over clear
    acc(0, 1, 7'h04, 32'h55, r);
    both(1, 7'h04, 32'h66, 1, 7'h08, 32'h1, r, r2);
    acc(1, 0, 7'h08, 0, r); chk("R5 set beats clear", r, 32'h1);
    acc(1, 1, 7'h08, 32'h1, r);
    acc(1, 0, 7'h08, 0, r); chk("R5 cleared after", r, 0);

    // R8 / R9 lock bank
    for (int n = 0; n < 32; n++) begin
      logic [6:0] la;
      la = 7'h40 + 7'(n);
      acc(0, 0, la, 0, r); chk("R8 claim free", r, 0);
      acc(0, 0, la, 0, r); chk("R8 second read held", r, 1);
      acc(1, 0, la, 0, r); chk("R8 other side held", r, 1);
      acc(1, 1, la, 0, r);
      acc(1, 1, la, 1, r);
      acc(0, 0, la, 0, r); chk("R9 release and write-1 ignored", r, 0);
      acc(1, 0, la, 0, r); chk("R9 reclaimed held", r, 1);
      acc(0, 1, la, 0, r);
    end

    // R10 simultaneous claims
    for (int k = 0; k < 3; k++) begin
      logic [6:0] la;
      la = 7'h40 + 7'(k * 15);
      both(0, la, 0, 0, la, 0, r, r2);
      chk("R10 cpu wins", r, 0);
      chk("R10 mcu sees held", r2, 1);
      acc(1, 0, la, 0, r); chk("R10 lock held", r, 1);
      acc(0, 1, la, 0, r);
    end
    both(0, 7'h41, 0, 0, 7'h42, 0, r, r2);
    chk("R10 distinct locks cpu", r, 0);
    chk("R10 distinct locks mcu", r2, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule